// File: doc/BRIEF.md
# Miss Status Holding Register Entry

This block is a single tracking entry for one outstanding miss in a non-blocking cache. When the cache misses, it allocates an idle entry. The entry latches the block address and becomes the collection point for every later request to that block. It keeps waiting requests in two in-order queues. The active list is served when the fill returns. The deferred list holds requests that cannot share the outstanding request and must wait for the fill to be promoted. Each queued target records the requester entry identity, a global order number, a ready time, an arrival stamp, whether it came from the CPU side or from a memory-side snoop, and whether it marked its requester as downstream-pending.

Entries form chains. When a target marks its requester, the entry pulses a one-hot bit on a vector indexed by requester identity, and that bit drives the requester's set input. When this entry's own downstream-pending flag is cleared, it passes the clear upstream as one-hot bits for every marked active target, one cycle later. A fill promotes the deferred targets: their marks are cleared upstream first, then they join the tail of the active list in arrival order. The entry is freed on the edge that pops its last active target.

Top module: `mshr_entry`

## Requirements
- R1: With the entry idle, an input of kind 2'b01 (allocate) makes it busy and captures the address. The request becomes the only active target, CPU-side and marked. Active flags take the request's exclusive and upgrade bits, and the deferred flags and both pending-snoop flags clear. An allocate while busy is ignored.
- R2: A request of kind 2'b10 (CPU) joins the deferred list when the deferred list is non-empty, when pend_inval is set, or when it is exclusive and act_excl is clear. Otherwise it joins the active list.
- R3: A CPU request added to the active list is marked only if in_service is clear. A request added to the deferred list is always marked. For every marked target added, mark_out carries exactly the bit at in_id on the following cycle, and is zero otherwise.
- R4: An exclusive CPU request sets the exclusive flag of the list it joins. An upgrade CPU request sets that list's upgrade flag.
- R5: A request of kind 2'b11 (snoop) joins the active list as a memory-side target. It is marked only when dsp_pending and act_excl are both set. An exclusive snoop sets pend_inval, and any other snoop sets pend_shared.
- R6: dsp_clr_in has no effect while dsp_pending is clear. Otherwise it clears dsp_pending, and on the next cycle clr_out has one bit set for the identity of every marked active target.
- R7: A fill with a non-empty deferred list pulses clr_out next cycle for every marked deferred target. The deferred targets then move to the active tail in order with their marks cleared, act_excl sets, and the deferred flags clear.
- R8: full is high while busy when the two lists together hold DEPTH targets, or after the fill. CPU and snoop requests are ignored while full or in the cycle of an accepted fill.
- R9: tgt_pop removes the active head only after the fill. busy falls on the edge that pops the last target.
- R10: Each target records in_id, in_order and in_ready. It also records an arrival stamp equal to the number of clock edges since reset release before the accepting edge. The active head presents these fields.
- R11: svc_set sets in_service while busy and before the fill. A fill clears it.
- R12: dsp_set sets dsp_pending. When set and clear arrive together, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_kind | input | 2 | 01 allocate, 10 CPU, 11 snoop |
| in_addr | input | ADDR_W | Block address (allocate) |
| in_id | input | ID_W | Requester entry identity |
| in_order | input | ORD_W | Global order number |
| in_ready | input | TS_W | Ready time |
| in_excl | input | 1 | Request needs exclusive ownership |
| in_upg | input | 1 | Request is an upgrade |
| svc_set | input | 1 | Miss has been issued downstream |
| dsp_set | input | 1 | Set downstream-pending |
| dsp_clr_in | input | 1 | Clear downstream-pending |
| fill_valid | input | 1 | Fill response arrived |
| tgt_pop | input | 1 | Remove active head |
| busy | output | 1 | Entry allocated |
| blk_addr | output | ADDR_W | Captured block address |
| full | output | 1 | New requests stalled |
| in_service | output | 1 | Miss in service |
| dsp_pending | output | 1 | Downstream-pending flag |
| pend_inval | output | 1 | Invalidating snoop seen |
| pend_shared | output | 1 | Sharing snoop seen |
| act_excl | output | 1 | Active list needs exclusive |
| act_upg | output | 1 | Active list has upgrade |
| def_excl | output | 1 | Deferred list needs exclusive |
| def_upg | output | 1 | Deferred list has upgrade |
| act_count | output | CNT_W | Active targets |
| def_count | output | CNT_W | Deferred targets |
| head_valid | output | 1 | Active head present |
| head_id | output | ID_W | Head requester identity |
| head_order | output | ORD_W | Head order number |
| head_ready | output | TS_W | Head ready time |
| head_arrive | output | TS_W | Head arrival stamp |
| head_cpu | output | 1 | Head came from CPU side |
| head_marked | output | 1 | Head marked its requester |
| mark_out | output | N_REQ | One-hot mark pulse by requester |
| clr_out | output | N_REQ | Clear-propagation pulses by requester |

## Verification
A request routed to the wrong list shows up at the next clock as a wrong act_count or def_count, and it changes the order in which heads appear after the fill. A wrong mark bit cannot be seen directly at the port. It appears on mark_out one cycle after acceptance, and again on clr_out when a later clear or fill propagates, which may be many cycles later. The bench therefore compares the head fields on every pop, so that a corrupted stored target is caught when it reaches the head.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  localparam int N_REQ = 16;
  localparam int ID_W  = $clog2(N_REQ);
  localparam int ORD_W = 16;
  localparam int TS_W  = 16;

  typedef enum logic [1:0] {
    K_NONE  = 2'b00,
    K_ALLOC = 2'b01,
    K_CPU   = 2'b10,
    K_SNOOP = 2'b11
  } in_kind_e;

  typedef struct packed {
    logic [ID_W-1:0]  id;
    logic [ORD_W-1:0] order;
    logic [TS_W-1:0]  ready;
    logic [TS_W-1:0]  arrive;
    logic             cpu;
    logic             marked;
  } tgt_t;
endpackage

// File: rtl/mshr_route.sv
module mshr_route (
  input  logic is_snoop,
  input  logic excl,
  input  logic def_nonempty,
  input  logic pend_inval,
  input  logic act_excl,
  input  logic in_service,
  input  logic dsp,
  output logic to_def,
  output logic mark
);
  always_comb begin
    to_def = !is_snoop && (def_nonempty || pend_inval || (excl && !act_excl));
    if (is_snoop) mark = dsp && act_excl;
    else          mark = to_def || !in_service;
  end
endmodule

// File: rtl/mshr_tgt_list.sv
module mshr_tgt_list import mshr_pkg::*; #(
  parameter  int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH+1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push,
  input  tgt_t                   push_tgt,
  input  logic                   pop,
  input  logic                   app,
  input  tgt_t [DEPTH-1:0]       app_ents,
  input  logic [CNT_W-1:0]       app_cnt,
  input  logic                   flush,
  output tgt_t [DEPTH-1:0]       ents,
  output logic [CNT_W-1:0]       cnt
);
  tgt_t [DEPTH-1:0] ents_n;
  logic [CNT_W-1:0] cnt_n;
  logic             upd;

  assign upd = push | pop | app | flush;

  always_comb begin
    ents_n = ents;
    cnt_n  = cnt;
    if (flush) begin
      cnt_n = '0;
    end else if (app) begin
      for (int j = 0; j < DEPTH; j++) begin
        for (int k = 0; k < DEPTH; k++) begin
          if ((k < int'(app_cnt)) && (j == int'(cnt) + k)) ents_n[j] = app_ents[k];
        end
      end
      cnt_n = cnt + app_cnt;
    end else if (pop && cnt != '0) begin
      for (int j = 0; j < DEPTH-1; j++) ents_n[j] = ents[j+1];
      cnt_n = cnt - 1'b1;
    end else if (push && int'(cnt) < DEPTH) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (j == int'(cnt)) ents_n[j] = push_tgt;
      end
      cnt_n = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ents <= '0;
      cnt  <= '0;
    end else if (upd) begin
      ents <= ents_n;
      cnt  <= cnt_n;
    end
  end
endmodule

// File: rtl/mshr_clr_fan.sv
module mshr_clr_fan import mshr_pkg::*; #(
  parameter  int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH+1)
) (
  input  logic                        en,
  input  logic [DEPTH-1:0]            mk,
  input  logic [DEPTH-1:0][ID_W-1:0]  ids,
  input  logic [CNT_W-1:0]            cnt,
  output logic [N_REQ-1:0]            vec
);
  always_comb begin
    vec = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (en && (j < int'(cnt)) && mk[j]) vec[ids[j]] = 1'b1;
    end
  end
endmodule

// File: rtl/mshr_entry.sv
module mshr_entry import mshr_pkg::*; #(
  parameter  int DEPTH  = 8,
  parameter  int ADDR_W = 26,
  localparam int CNT_W  = $clog2(DEPTH+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_kind,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [ID_W-1:0]   in_id,
  input  logic [ORD_W-1:0]  in_order,
  input  logic [TS_W-1:0]   in_ready,
  input  logic              in_excl,
  input  logic              in_upg,
  input  logic              svc_set,
  input  logic              dsp_set,
  input  logic              dsp_clr_in,
  input  logic              fill_valid,
  input  logic              tgt_pop,
  output logic              busy,
  output logic [ADDR_W-1:0] blk_addr,
  output logic              full,
  output logic              in_service,
  output logic              dsp_pending,
  output logic              pend_inval,
  output logic              pend_shared,
  output logic              act_excl,
  output logic              act_upg,
  output logic              def_excl,
  output logic              def_upg,
  output logic [CNT_W-1:0]  act_count,
  output logic [CNT_W-1:0]  def_count,
  output logic              head_valid,
  output logic [ID_W-1:0]   head_id,
  output logic [ORD_W-1:0]  head_order,
  output logic [TS_W-1:0]   head_ready,
  output logic [TS_W-1:0]   head_arrive,
  output logic              head_cpu,
  output logic              head_marked,
  output logic [N_REQ-1:0]  mark_out,
  output logic [N_REQ-1:0]  clr_out
);
  logic              valid_q, valid_n, filled_q, filled_n, svc_q, svc_n, dsp_q, dsp_n;
  logic              pinv_q, pinv_n, pshr_q, pshr_n;
  logic              aex_q, aex_n, aup_q, aup_n, dex_q, dex_n, dup_q, dup_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [TS_W-1:0]   stamp_q;
  logic [N_REQ-1:0]  mark_q, mark_n, clr_q, clr_n, act_vec, def_vec;

  tgt_t [DEPTH-1:0]  act_ents, def_ents, app_ents;
  logic [CNT_W-1:0]  a_cnt, d_cnt;
  logic [DEPTH-1:0]  act_mk, def_mk;
  logic [DEPTH-1:0][ID_W-1:0] act_ids, def_ids;
  logic [CNT_W:0]    tot;

  logic full_w, acc_alloc, acc_cpu, acc_snp, do_fill, do_pop, do_clr, splice;
  logic to_def, route_mark, a_push, d_push;
  tgt_t new_tgt;

  assign tot       = {1'b0, a_cnt} + {1'b0, d_cnt};
  assign full_w    = valid_q && (filled_q || tot == (CNT_W+1)'(DEPTH));
  assign do_fill   = fill_valid && valid_q && !filled_q;
  assign acc_alloc = in_valid && in_kind == K_ALLOC && !valid_q;
  assign acc_cpu   = in_valid && in_kind == K_CPU   && valid_q && !full_w && !do_fill;
  assign acc_snp   = in_valid && in_kind == K_SNOOP && valid_q && !full_w && !do_fill;
  assign do_pop    = tgt_pop && valid_q && filled_q && a_cnt != '0;
  assign do_clr    = dsp_clr_in && dsp_q;
  assign splice    = do_fill && d_cnt != '0;

  mshr_route u_route (
    .is_snoop(in_kind == K_SNOOP), .excl(in_excl), .def_nonempty(d_cnt != '0),
    .pend_inval(pinv_q), .act_excl(aex_q), .in_service(svc_q), .dsp(dsp_q),
    .to_def(to_def), .mark(route_mark)
  );

  assign a_push = acc_alloc || acc_snp || (acc_cpu && !to_def);
  assign d_push = acc_cpu && to_def;

  always_comb begin
    new_tgt.id     = in_id;
    new_tgt.order  = in_order;
    new_tgt.ready  = in_ready;
    new_tgt.arrive = stamp_q;
    new_tgt.cpu    = !acc_snp;
    new_tgt.marked = acc_alloc ? 1'b1 : route_mark;
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_ext
      always_comb begin
        app_ents[g]        = def_ents[g];
        app_ents[g].marked = 1'b0;
      end
      assign act_mk[g]  = act_ents[g].marked;
      assign act_ids[g] = act_ents[g].id;
      assign def_mk[g]  = def_ents[g].marked;
      assign def_ids[g] = def_ents[g].id;
    end
  endgenerate

  mshr_tgt_list #(.DEPTH(DEPTH)) u_act (
    .clk(clk), .rst_n(rst_n), .push(a_push), .push_tgt(new_tgt), .pop(do_pop),
    .app(splice), .app_ents(app_ents), .app_cnt(d_cnt), .flush(1'b0),
    .ents(act_ents), .cnt(a_cnt)
  );

  mshr_tgt_list #(.DEPTH(DEPTH)) u_def (
    .clk(clk), .rst_n(rst_n), .push(d_push), .push_tgt(new_tgt), .pop(1'b0),
    .app(1'b0), .app_ents('0), .app_cnt('0), .flush(do_fill),
    .ents(def_ents), .cnt(d_cnt)
  );

  mshr_clr_fan #(.DEPTH(DEPTH)) u_act_fan (
    .en(do_clr), .mk(act_mk), .ids(act_ids), .cnt(a_cnt), .vec(act_vec));
  mshr_clr_fan #(.DEPTH(DEPTH)) u_def_fan (
    .en(splice), .mk(def_mk), .ids(def_ids), .cnt(d_cnt), .vec(def_vec));

  always_comb begin
    valid_n = valid_q; filled_n = filled_q; svc_n = svc_q; addr_n = addr_q;
    pinv_n = pinv_q; pshr_n = pshr_q;
    aex_n = aex_q; aup_n = aup_q; dex_n = dex_q; dup_n = dup_q;
    dsp_n = (dsp_q && !do_clr) || dsp_set;
    if (svc_set && valid_q && !filled_q) svc_n = 1'b1;
    if (acc_alloc) begin
      valid_n = 1'b1; filled_n = 1'b0; svc_n = 1'b0; addr_n = in_addr;
      aex_n = in_excl; aup_n = in_upg; dex_n = 1'b0; dup_n = 1'b0;
      pinv_n = 1'b0; pshr_n = 1'b0;
    end
    if (acc_cpu && !to_def) begin
      aex_n = aex_q || in_excl; aup_n = aup_q || in_upg;
    end
    if (d_push) begin
      dex_n = dex_q || in_excl; dup_n = dup_q || in_upg;
    end
    if (acc_snp) begin
      if (in_excl) pinv_n = 1'b1;
      else         pshr_n = 1'b1;
    end
    if (do_fill) begin
      svc_n = 1'b0; filled_n = 1'b1;
      if (splice) begin
        aex_n = 1'b1; dex_n = 1'b0; dup_n = 1'b0;
      end
    end
    if (do_pop && a_cnt == CNT_W'(1)) begin
      valid_n = 1'b0; filled_n = 1'b0;
    end
    mark_n = ((a_push || d_push) && new_tgt.marked) ? (N_REQ'(1) << in_id) : '0;
    clr_n  = act_vec | def_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0; filled_q <= 1'b0; svc_q <= 1'b0; dsp_q <= 1'b0;
      pinv_q <= 1'b0; pshr_q <= 1'b0;
      aex_q <= 1'b0; aup_q <= 1'b0; dex_q <= 1'b0; dup_q <= 1'b0;
      addr_q <= '0; stamp_q <= '0; mark_q <= '0; clr_q <= '0;
    end else begin
      valid_q <= valid_n; filled_q <= filled_n; svc_q <= svc_n; dsp_q <= dsp_n;
      pinv_q <= pinv_n; pshr_q <= pshr_n;
      aex_q <= aex_n; aup_q <= aup_n; dex_q <= dex_n; dup_q <= dup_n;
      stamp_q <= stamp_q + 1'b1;
      mark_q <= mark_n; clr_q <= clr_n;
      if (acc_alloc) addr_q <= addr_n;
    end
  end

  assign busy        = valid_q;
  assign blk_addr    = addr_q;
  assign full        = full_w;
  assign in_service  = svc_q;
  assign dsp_pending = dsp_q;
  assign pend_inval  = pinv_q;
  assign pend_shared = pshr_q;
  assign act_excl    = aex_q;
  assign act_upg     = aup_q;
  assign def_excl    = dex_q;
  assign def_upg     = dup_q;
  assign act_count   = a_cnt;
  assign def_count   = d_cnt;
  assign head_valid  = a_cnt != '0;
  assign head_id     = act_ents[0].id;
  assign head_order  = act_ents[0].order;
  assign head_ready  = act_ents[0].ready;
  assign head_arrive = act_ents[0].arrive;
  assign head_cpu    = act_ents[0].cpu;
  assign head_marked = act_ents[0].marked;
  assign mark_out    = mark_q;
  assign clr_out     = clr_q;
endmodule

// File: rtl/mshr_entry_chk.sv
module mshr_entry_chk import mshr_pkg::*; #(
  parameter  int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH+1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       in_kind,
  input logic             dsp_clr_in,
  input logic             fill_valid,
  input logic             tgt_pop,
  input logic             busy,
  input logic             full,
  input logic             dsp_pending,
  input logic             pend_inval,
  input logic             act_excl,
  input logic             head_marked,
  input logic [CNT_W-1:0] act_count,
  input logic [CNT_W-1:0] def_count,
  input logic [N_REQ-1:0] mark_out,
  input logic [N_REQ-1:0] clr_out
);
  // R8
  cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, act_count} + {1'b0, def_count}) <= (CNT_W+1)'(DEPTH));

  // R3
  mark_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mark_out));

  // R6
  clr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_clr_in && !dsp_pending && !fill_valid) |=> (clr_out == '0));

  // R9
  free_on_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tgt_pop));

  // R1
  alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 2'b01 && !busy) |=>
      (busy && act_count == CNT_W'(1) && def_count == '0 && head_marked && !pend_inval));

  // R7
  splice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && busy && def_count != '0) |=>
      (def_count == '0 && act_excl &&
       act_count == $past(act_count) + $past(def_count)));

  // R2
  inval_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 2'b10 && busy && !full && !fill_valid && pend_inval) |=>
      (def_count == $past(def_count) + 1'b1));
endmodule

bind mshr_entry mshr_entry_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
  .dsp_clr_in(dsp_clr_in), .fill_valid(fill_valid), .tgt_pop(tgt_pop),
  .busy(busy), .full(full), .dsp_pending(dsp_pending), .pend_inval(pend_inval),
  .act_excl(act_excl), .head_marked(head_marked), .act_count(act_count),
  .def_count(def_count), .mark_out(mark_out), .clr_out(clr_out)
);

// File: tb/sim_mshr_entry.sv
`timescale 1ns/1ps
module sim_mshr_entry;
  import mshr_pkg::*;
  localparam int DEPTH  = 8;
  localparam int ADDR_W = 26;
  localparam int CNT_W  = $clog2(DEPTH+1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid, in_excl, in_upg, svc_set, dsp_set, dsp_clr_in, fill_valid, tgt_pop;
  logic [1:0] in_kind;
  logic [ADDR_W-1:0] in_addr;
  logic [ID_W-1:0] in_id;
  logic [ORD_W-1:0] in_order;
  logic [TS_W-1:0] in_ready;
  logic busy, full, in_service, dsp_pending, pend_inval, pend_shared;
  logic act_excl, act_upg, def_excl, def_upg, head_valid, head_cpu, head_marked;
  logic [ADDR_W-1:0] blk_addr;
  logic [CNT_W-1:0] act_count, def_count;
  logic [ID_W-1:0] head_id;
  logic [ORD_W-1:0] head_order;
  logic [TS_W-1:0] head_ready, head_arrive;
  logic [N_REQ-1:0] mark_out, clr_out;

  always #5 clk = ~clk;

  mshr_entry #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u0 (.*);

  int checks = 0, errs = 0;
  bit done = 0;

  // reference state
  bit busy_m, filled_m, svc_m, dsp_m, pinv_m, pshr_m, aex_m, aup_m, dex_m, dup_m;
  logic [ADDR_W-1:0] addr_m;
  tgt_t aq[$], dq[$];
  int unsigned stamp_m;
  logic [N_REQ-1:0] mark_e, clr_e;

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic idle();
    in_valid = 0; in_kind = 2'b00; in_addr = '0; in_id = '0; in_order = '0;
    in_ready = '0; in_excl = 0; in_upg = 0; svc_set = 0; dsp_set = 0;
    dsp_clr_in = 0; fill_valid = 0; tgt_pop = 0;
  endtask

  task automatic compare();
    chk("R9 busy", busy, busy_m);
    chk("R8 full", full, busy_m && (filled_m || aq.size() + dq.size() == DEPTH));
    chk("R11 in_service", in_service, svc_m);
    chk("R12 dsp_pending", dsp_pending, dsp_m);
    chk("R5 pend_inval", pend_inval, pinv_m);
    chk("R5 pend_shared", pend_shared, pshr_m);
    chk("R4 act_excl", act_excl, aex_m);
    chk("R4 act_upg", act_upg, aup_m);
    chk("R4 def_excl", def_excl, dex_m);
    chk("R4 def_upg", def_upg, dup_m);
    chk("R2 act_count", act_count, aq.size());
    chk("R2 def_count", def_count, dq.size());
    chk("R3 mark_out", mark_out, mark_e);
    chk("R6 R7 clr_out", clr_out, clr_e);
    chk("R10 head_valid", head_valid, aq.size() != 0);
    if (busy_m) chk("R1 blk_addr", blk_addr, addr_m);
    if (aq.size() != 0) begin
      chk("R10 head_id", head_id, aq[0].id);
      chk("R10 head_order", head_order, aq[0].order);
      chk("R10 head_ready", head_ready, aq[0].ready);
      chk("R10 head_arrive", head_arrive, aq[0].arrive);
      chk("R5 head_cpu", head_cpu, aq[0].cpu);
      chk("R3 head_marked", head_marked, aq[0].marked);
    end
  endtask

  // one clock: predict from requirements, advance, compare
  task automatic cycle();
    bit full_m, a_alloc, a_cpu, a_snp, do_fill, do_pop, to_def;
    tgt_t t;
    full_m  = busy_m && (filled_m || aq.size() + dq.size() == DEPTH);
    do_fill = fill_valid && busy_m && !filled_m;
    a_alloc = in_valid && in_kind == 2'b01 && !busy_m;
    a_cpu   = in_valid && in_kind == 2'b10 && busy_m && !full_m && !do_fill;
    a_snp   = in_valid && in_kind == 2'b11 && busy_m && !full_m && !do_fill;
    do_pop  = tgt_pop && busy_m && filled_m && aq.size() != 0;
    to_def  = a_cpu && (dq.size() != 0 || pinv_m || (in_excl && !aex_m));
    t.id = in_id; t.order = in_order; t.ready = in_ready;
    t.arrive = stamp_m[TS_W-1:0]; t.cpu = !a_snp;
    t.marked = a_alloc ? 1'b1 : a_snp ? (dsp_m && aex_m) : (to_def || !svc_m);
    mark_e = '0; clr_e = '0;
    if (dsp_clr_in && dsp_m) begin
      foreach (aq[i]) if (aq[i].marked) clr_e[aq[i].id] = 1'b1;
      dsp_m = 0;
    end
    if (dsp_set) dsp_m = 1;
    if (svc_set && busy_m && !filled_m) svc_m = 1;
    if (a_alloc) begin
      busy_m = 1; filled_m = 0; svc_m = 0; addr_m = in_addr;
      aex_m = in_excl; aup_m = in_upg; dex_m = 0; dup_m = 0; pinv_m = 0; pshr_m = 0;
      aq.delete(); aq.push_back(t);
    end
    if (a_cpu) begin
      if (to_def) begin dq.push_back(t); dex_m |= in_excl; dup_m |= in_upg; end
      else begin aq.push_back(t); aex_m |= in_excl; aup_m |= in_upg; end
    end
    if (a_snp) begin
      aq.push_back(t);
      if (in_excl) pinv_m = 1; else pshr_m = 1;
    end
    if ((a_alloc || a_cpu || a_snp) && t.marked) mark_e[in_id] = 1'b1;
    if (do_fill) begin
      svc_m = 0; filled_m = 1;
      if (dq.size() != 0) begin
        aex_m = 1; dex_m = 0; dup_m = 0;
        foreach (dq[i]) begin
          tgt_t u = dq[i];
          if (u.marked) clr_e[u.id] = 1'b1;
          u.marked = 1'b0;
          aq.push_back(u);
        end
        dq.delete();
      end
    end
    if (do_pop) begin
      void'(aq.pop_front());
      if (aq.size() == 0) begin busy_m = 0; filled_m = 0; end
    end
    stamp_m++;
    @(negedge clk);
    idle();
    compare();
  endtask

  task automatic put(logic [1:0] k, bit ex, bit up);
    in_valid = 1; in_kind = k; in_excl = ex; in_upg = up;
    in_addr = ADDR_W'($urandom); in_id = ID_W'($urandom);
    in_order = ORD_W'($urandom); in_ready = TS_W'($urandom);
  endtask

  task automatic drain();
    int guard = 0;
    fill_valid = 1; cycle();
    while (busy_m && guard < 100) begin
      tgt_pop = ($urandom % 3) != 0;
      if ($urandom % 4 == 0) put(2'b10, 0, 0);
      cycle(); guard++;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    idle();
    stamp_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare();  // reset state

    // R1 allocate, then allocate while busy ignored
    put(2'b01, 0, 1); cycle();
    chk("R1 busy after alloc", busy, 1);
    put(2'b01, 1, 0); cycle();
    // R9 pop before fill ignored
    tgt_pop = 1; cycle();
    // R2 exclusive against non-exclusive active -> deferred, later plain also deferred
    put(2'b10, 1, 0); cycle();
    put(2'b10, 0, 0); cycle();
    // R8 fill to capacity, then overflow request ignored
    while (aq.size() + dq.size() < DEPTH) begin put(2'b10, 0, 1); cycle(); end
    put(2'b11, 1, 0); cycle();
    chk("R8 full holds", full, 1);
    // R6 clear while not pending ignored; then set and clear
    dsp_clr_in = 1; cycle();
    dsp_set = 1; cycle();
    dsp_clr_in = 1; dsp_set = 1; cycle();   // R12 set wins
    dsp_clr_in = 1; cycle();
    // R7 fill promotes deferred
    drain();
    chk("R7 freed after drain", busy, 0);

    // R5 snoop marking with dsp and exclusive active
    put(2'b01, 1, 0); cycle();
    dsp_set = 1; cycle();
    put(2'b11, 0, 0); cycle();
    put(2'b11, 1, 0); cycle();
    put(2'b10, 0, 0); cycle();          // R2 pend_inval forces deferral
    svc_set = 1; cycle();               // R11
    drain();

    for (int r = 0; r < 60; r++) begin
      put(2'b01, $urandom % 2, $urandom % 2); cycle();
      for (int c = 0; c < 4 + int'($urandom % 12); c++) begin
        if ($urandom % 4 != 0) begin
          int s = $urandom % 10;
          put(s < 6 ? 2'b10 : s < 9 ? 2'b11 : 2'b01, $urandom % 2, $urandom % 4 == 0);
        end
        svc_set    = ($urandom % 6) == 0;
        dsp_set    = ($urandom % 5) == 0;
        dsp_clr_in = ($urandom % 4) == 0;
        cycle();
      end
      dsp_clr_in = ($urandom % 2) == 0;
      drain();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog got 0 exp 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end
endmodule